// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block is the master-mode timing source of a video output path. From the pixel clock it runs a horizontal pixel counter and a line counter over a raster whose line length, blanking length and frame height are parameters (defaults describe an interlaced 625-line frame of 864 clocks per line). From those counters it derives a line sync pulse, a frame sync pulse, a field flag that marks the second interlaced field, and a pixel-data-valid strobe.

A single 8-bit control register sets the pulse widths and the relative positions of the outputs. Widths and offsets are not linear counts: each two-bit code selects one entry of a small table of clock counts. One two-bit field is read differently depending on the timing-mode input. In mode 1 its upper bit adds a long delay, one half-line by default, before the field flag rises. In mode 2 it sets the frame sync width. The host writes and reads the register through a plain address/data port. A new value and a new mode are held back until the first pixel of the next frame, so no pulse is ever cut short or stretched.

Top module: `sync_timing_gen`

## Requirements
- R1: While reset is asserted, hsync, vsync, field and pix_valid are 0 and the control register reads 0x00.
- R2: The control register is 8 bits wide at address 0x0C. It reads back the last value written there. A read at any other address returns 0x00. A write to any other address leaves the register unchanged.
- R3: Counting from the first clock of a line as clock 0, pix_valid rises at clock H_BLANK of every line and stays high for H_TOTAL-H_BLANK clocks.
- R4: The hsync pulse width is chosen by register bits [1:0]: code 0 gives 1 clock, 1 gives 4, 2 gives 16 and 3 gives 128.
- R5: hsync rises at clock S = skew + hoff of every line. skew is bits [7:6] read as 0..3 clocks. hoff is bits [3:2], where code 0 gives 0 clocks, 1 gives 4, 2 gives 8 and 3 gives 16.
- R6: When mode_sel is 1 (timing mode 2), vsync pulses once on line 0 and once on line (V_TOTAL+1)/2. Each pulse rises at clock skew, so hsync trails it by hoff. Its width is chosen by bits [5:4] from the same 1/4/16/128 table.
- R7: When mode_sel is 0 (timing mode 1), vsync stays low.
- R8: field is high during the second field. It falls on line 0 at clock S. It rises on line (V_TOTAL+1)/2 at clock S, plus EXT_CLKS when mode 1 is active and bit 5 is 1. Bit 4 has no effect on field in mode 1, and bit 5 has no effect on field in mode 2.
- R9: A register write or mode change during a frame leaves the rest of that frame unchanged. The new settings apply from line 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| mode_sel | input | 1 | 0 = timing mode 1, 1 = timing mode 2; sampled at frame start |
| hsync | output | 1 | Line sync pulse, active high |
| vsync | output | 1 | Frame sync pulse, active high (mode 2 only) |
| field | output | 1 | High during the second interlaced field |
| pix_valid | output | 1 | High while pixel data is active |

## Verification
Every output is registered once behind the counters. hsync, vsync, field and pix_valid therefore share one fixed latency, and each line can be measured in clocks from the cycle in which pix_valid falls. The bench samples on the falling clock edge. For every line it records the clock index of each rise, fall or field change and the length of each pulse, then compares them with values computed from the register code used for that line. Read data is combinational, so a readback is checked one clock after the write strobe. A new configuration is written in line 1, and the bench checks that the remaining lines of that frame keep the old timing while line 0 of the next frame uses the new one.

// File: rtl/stg_pkg.sv
package stg_pkg;

   // control register layout; positions are decoded by the timing logic
   typedef struct packed {
      logic [1:0] skew;    // line sync shift against pixel data
      logic [1:0] vfield;  // mode 2: frame sync width, mode 1: bit 1 = long field delay
      logic [1:0] hoff;    // line sync offset from frame reference
      logic [1:0] hwid;    // line sync width
   } stg_cfg_t;

   localparam int STG_MAX_WIDTH = 128;
   localparam int STG_MAX_LEAD  = 3 + 16;
   localparam int STG_CNT_W     = $clog2(STG_MAX_WIDTH + 1);

   function automatic logic [7:0] stg_dec_width(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd1;
         2'd1:    return 8'd4;
         2'd2:    return 8'd16;
         default: return 8'd128;
      endcase
   endfunction

   function automatic logic [4:0] stg_dec_offset(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd0;
         2'd1:    return 5'd4;
         2'd2:    return 5'd8;
         default: return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/stg_raster.sv
module stg_raster #(
   parameter int H_TOTAL = 864,
   parameter int V_TOTAL = 625,
   parameter int H_BLANK = 144,
   parameter int H_W     = 10,
   parameter int V_W     = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [H_W-1:0] h_cnt,
   output logic [V_W-1:0] v_cnt,
   output logic           frame_wrap,
   output logic           pix_valid
);

   localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
   localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);
   localparam logic [H_W-1:0] H_ACT  = H_W'(H_BLANK);

   assign frame_wrap = (h_cnt == H_LAST) && (v_cnt == V_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt     <= '0;
         v_cnt     <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= (h_cnt >= H_ACT);
         if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   // R3: pixel counter never leaves the line
   a_r3_h_range: assert property (@(posedge clk) disable iff (!rst_n)
      h_cnt <= H_LAST);

   // R3: line counter only moves at the end of a line
   a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt != H_LAST) |=> $stable(v_cnt));

endmodule

// File: rtl/stg_ctrl_reg.sv
module stg_ctrl_reg
   import stg_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int REG_ADDR = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_wr,
   output logic [7:0]        reg_rdata,
   input  logic              mode_sel,
   input  logic              frame_wrap,
   output stg_cfg_t          act_cfg,
   output logic              act_mode2
);

   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

   stg_cfg_t shadow;

   assign reg_rdata = (reg_addr == SEL) ? shadow : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow    <= '0;
         act_cfg   <= '0;
         act_mode2 <= 1'b0;
      end else begin
         if (reg_wr && (reg_addr == SEL)) shadow <= reg_wdata;
         if (frame_wrap) begin
            act_cfg   <= shadow;
            act_mode2 <= mode_sel;
         end
      end
   end

   // R9: active settings only move at the frame boundary
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_wrap |=> ($stable(act_cfg) && $stable(act_mode2)));

   // R2: a write elsewhere leaves the shadow alone
   a_r2_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != SEL) |=> $stable(shadow));

endmodule

// File: rtl/stg_pulse.sv
module stg_pulse #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [CNT_W-1:0] len,
   output logic             active
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (fire)         cnt <= len;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);

   // R4: a started pulse shortens by one clock each cycle
   a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !fire) |=> (cnt == $past(cnt) - 1'b1));

   // R4: a trigger loads the decoded length
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == $past(len)));

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
   import stg_pkg::*;
#(
   parameter int H_TOTAL  = 864,
   parameter int V_TOTAL  = 625,
   parameter int H_BLANK  = 144,
   parameter int EXT_CLKS = 432,
   parameter int ADDR_W   = 5,
   parameter int REG_ADDR = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_wr,
   output logic [7:0]        reg_rdata,
   input  logic              mode_sel,
   output logic              hsync,
   output logic              vsync,
   output logic              field,
   output logic              pix_valid
);

   localparam int H_W        = $clog2(H_TOTAL);
   localparam int V_W        = $clog2(V_TOTAL);
   localparam int FIELD_LINE = (V_TOTAL + 1) / 2;
   localparam int N_CH       = 2;   // 0: line sync, 1: frame sync

   // elaboration checks on the parameter set
   if (H_TOTAL <= STG_MAX_LEAD + STG_MAX_WIDTH + 1) begin : g_bad_line_len
      initial $error("H_TOTAL too short for the widest line sync pulse");
   end
   if (H_TOTAL <= STG_MAX_LEAD + EXT_CLKS + 1) begin : g_bad_ext
      initial $error("EXT_CLKS does not fit inside one line");
   end
   if (V_TOTAL < 3 || (V_TOTAL % 2) == 0) begin : g_bad_lines
      initial $error("V_TOTAL must be odd and at least 3 for interlace");
   end
   if (H_BLANK < 1 || H_BLANK >= H_TOTAL) begin : g_bad_blank
      initial $error("H_BLANK must lie inside the line");
   end
   if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      initial $error("REG_ADDR does not fit in ADDR_W bits");
   end

   logic [H_W-1:0] h_cnt;
   logic [V_W-1:0] v_cnt;
   logic           frame_wrap;
   stg_cfg_t       act_cfg;
   logic           act_mode2;

   stg_raster #(
      .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_BLANK(H_BLANK),
      .H_W(H_W), .V_W(V_W)
   ) u_raster (
      .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .frame_wrap(frame_wrap), .pix_valid(pix_valid)
   );

   stg_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .mode_sel(mode_sel),
      .frame_wrap(frame_wrap), .act_cfg(act_cfg), .act_mode2(act_mode2)
   );

   // decoded positions within the line
   logic [H_W-1:0] skew_pt;
   logic [H_W-1:0] hs_start;
   logic [H_W-1:0] field_pt;
   logic           first_line_of_field;

   assign skew_pt  = H_W'(act_cfg.skew);
   assign hs_start = skew_pt + H_W'(stg_dec_offset(act_cfg.hoff));
   assign field_pt = hs_start +
                     ((!act_mode2 && act_cfg.vfield[1]) ? H_W'(EXT_CLKS) : '0);
   assign first_line_of_field = (v_cnt == '0) || (v_cnt == V_W'(FIELD_LINE));

   logic [N_CH-1:0]      ch_fire;
   logic [STG_CNT_W-1:0] ch_len [N_CH];
   logic [N_CH-1:0]      ch_out;

   assign ch_fire[0] = (h_cnt == hs_start);
   assign ch_len[0]  = STG_CNT_W'(stg_dec_width(act_cfg.hwid));
   assign ch_fire[1] = act_mode2 && first_line_of_field && (h_cnt == skew_pt);
   assign ch_len[1]  = STG_CNT_W'(stg_dec_width(act_cfg.vfield));

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      stg_pulse #(.CNT_W(STG_CNT_W)) u_pulse (
         .clk(clk), .rst_n(rst_n), .fire(ch_fire[g]),
         .len(ch_len[g]), .active(ch_out[g])
      );
   end

   assign hsync = ch_out[0];
   assign vsync = ch_out[1];

   logic field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= 1'b0;
      else if ((v_cnt == V_W'(FIELD_LINE)) && (h_cnt == field_pt))
         field_q <= 1'b1;
      else if ((v_cnt == '0) && (h_cnt == hs_start))
         field_q <= 1'b0;
   end

   assign field = field_q;

   // R7: no frame sync while timing mode 1 is active
   a_r7_no_vs_mode1: assert property (@(posedge clk) disable iff (!rst_n)
      !act_mode2 |-> !vsync);

   // R8: the field flag only changes on the first line of a field
   a_r8_field_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_q) |-> first_line_of_field);

   // R5: line sync starts one clock after the counter passes its start point
   a_r5_hs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> ($past(h_cnt) == $past(hs_start)));

endmodule

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;

   localparam int H_TOT = 300;
   localparam int V_TOT = 5;
   localparam int H_BLK = 160;
   localparam int EXT   = 100;
   localparam int FB    = (V_TOT + 1) / 2;
   localparam int N_CFG = 96;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] reg_addr = 5'h0C;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_wr = 1'b0;
   logic       mode_sel = 1'b0;
   logic [7:0] reg_rdata;
   logic       hsync, vsync, field, pix_valid;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   sync_timing_gen #(
      .H_TOTAL(H_TOT), .V_TOTAL(V_TOT), .H_BLANK(H_BLK), .EXT_CLKS(EXT),
      .ADDR_W(5), .REG_ADDR(12)
   ) u_sync_timing_gen (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .mode_sel(mode_sel),
      .hsync(hsync), .vsync(vsync), .field(field), .pix_valid(pix_valid)
   );

   function automatic int wid(input logic [1:0] c);
      case (c)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 16;
         default: return 128;
      endcase
   endfunction

   function automatic int offs(input logic [1:0] c);
      return (c == 2'd0) ? 0 : 4 * (1 << (int'(c) - 1));
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_total++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // measure one line starting at its clock 0; optional write during the line
   task automatic meas_line(input int L, input logic [7:0] c, input bit m2,
                            input bit do_wr, input logic [7:0] wv, input bit wm);
      int hs_first = -1, hs_cnt = 0, vs_first = -1, vs_cnt = 0;
      int de_first = -1, de_cnt = 0, f_chg = -1;
      int s, e_f0, e_fchg, e_vsf, e_vsc;
      s    = int'(c[7:6]) + offs(c[3:2]);
      e_f0 = (L == 0) ? 1 : ((L <= FB) ? 0 : 1);
      if (L == 0)       e_fchg = s;
      else if (L == FB) e_fchg = s + ((!m2 && c[5]) ? EXT : 0);
      else              e_fchg = -1;
      if (m2 && (L == 0 || L == FB)) begin
         e_vsf = int'(c[7:6]);
         e_vsc = wid(c[5:4]);
      end else begin
         e_vsf = -1;
         e_vsc = 0;
      end
      for (int k = 0; k < H_TOT; k++) begin
         if (hsync) begin if (hs_first < 0) hs_first = k; hs_cnt++; end
         if (vsync) begin if (vs_first < 0) vs_first = k; vs_cnt++; end
         if (pix_valid) begin if (de_first < 0) de_first = k; de_cnt++; end
         if (int'(field) != e_f0 && f_chg < 0) f_chg = k;
         if (do_wr) begin
            case (k)
               200: begin reg_addr = 5'h0C; reg_wdata = wv; reg_wr = 1'b1; mode_sel = wm; end
               201: reg_wr = 1'b0;
               202: begin reg_addr = 5'h0D; reg_wdata = ~wv; reg_wr = 1'b1; end
               203: reg_wr = 1'b0;
               204: begin chk("R2", "read of other address", int'(reg_rdata), 0); reg_addr = 5'h0C; end
               205: chk("R2", "readback after stray write", int'(reg_rdata), int'(wv));
               default: ;
            endcase
         end
         @(negedge clk);
      end
      chk("R3", $sformatf("pix_valid start line %0d", L), de_first, H_BLK);
      chk("R3", $sformatf("pix_valid length line %0d", L), de_cnt, H_TOT - H_BLK);
      chk("R4", $sformatf("hsync width cfg %02h", c), hs_cnt, wid(c[1:0]));
      chk((L == 0) ? "R9" : "R5", $sformatf("hsync start cfg %02h line %0d", c, L), hs_first, s);
      chk(m2 ? "R6" : "R7", $sformatf("vsync start cfg %02h line %0d", c, L), vs_first, e_vsf);
      chk(m2 ? "R6" : "R7", $sformatf("vsync width cfg %02h line %0d", c, L), vs_cnt, e_vsc);
      chk("R8", $sformatf("field edge cfg %02h mode2=%0d line %0d", c, m2, L), f_chg, e_fchg);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_total++;
         $display("FAIL R3 watchdog: actual %0d cycles expected fewer", 190000);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      logic [7:0] cur, nxt;
      bit         curm, nm;
      int         seed_v;
      seed_v = int'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "hsync in reset", int'(hsync), 0);
      chk("R1", "vsync in reset", int'(vsync), 0);
      chk("R1", "field in reset", int'(field), 0);
      chk("R1", "pix_valid in reset", int'(pix_valid), 0);
      chk("R1", "register in reset", int'(reg_rdata), 0);
      rst_n = 1'b1;
      while (!pix_valid) @(negedge clk);
      while (pix_valid) @(negedge clk);
      cur  = 8'h00;
      curm = 1'b0;
      for (int it = 0; it < N_CFG; it++) begin
         case (it)
            0: begin nxt = 8'h00; nm = 1'b1; end
            1: begin nxt = 8'hFF; nm = 1'b0; end
            2: begin nxt = 8'hEF; nm = 1'b0; end   // R8: bit 4 clear, same field timing as FF
            3: begin nxt = 8'hFF; nm = 1'b1; end
            4: begin nxt = 8'hDF; nm = 1'b1; end
            5: begin nxt = 8'h3C; nm = 1'b0; end
            6: begin nxt = 8'h00; nm = 1'b0; end
            7: begin nxt = 8'h55; nm = 1'b1; end
            default: begin nxt = 8'($urandom); nm = 1'($urandom); end
         endcase
         for (int L = 1; L < V_TOT; L++)
            meas_line(L, cur, curm, (L == 1), nxt, nm);
         meas_line(0, nxt, nm, 1'b0, 8'h00, 1'b0);
         cur  = nxt;
         curm = nm;
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule